// File: doc/BRIEF.md
# Edge-Interrupt General-Purpose I/O Bank

A bank of 32 general-purpose I/O lines controlled through a plain 32-bit register bus with separate read and write strobes. Software chooses for each line whether it is an input or an output. An output can be a push-pull driver or an open-drain driver. Each input passes through a per-line input buffer enable before it can be seen. Every pad input is first brought into the clock domain by a two-flop synchroniser.

Each line has its own edge detector. The detector watches either falling edges only or both edges. A detected edge sets a sticky event bit, and software clears that bit by writing a 1 to it. A per-line mask selects which event bits drive the single combined interrupt output.

Every register uses the same reversed bit order: line n sits at bit 31−n. The pad ports themselves are indexed by line number, so `pad_in[n]` is line n.

Top module: `pinbank_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0: direction, open-drain, data, event, mask, edge mode and input enable. `pad_oe` is all zero and `irq_out` is 0.
- R2: Line n is held at register bit 31−n in every register. `pad_in[n]`, `pad_out[n]` and `pad_oe[n]` belong to line n.
- R3: Writing the event register (offset 0x0C) clears each event bit whose write-data bit is 1. Event bits whose write-data bit is 0 keep their value.
- R4: If an edge is detected on a line in the same cycle as a write-1-to-clear of that line's event bit, the event bit stays set.
- R5: `irq_out` is 1 exactly when the event register ANDed with the mask register (offset 0x10, 1 = enabled) is nonzero.
- R6: The edge-mode register (offset 0x14) selects the edges that set a line's event bit. A bit of 1 detects falling edges only. A bit of 0 detects both rising and falling edges. Detection watches the synchronised pad value gated by the input enable.
- R7: A line whose direction bit (offset 0x00) is 0 never drives its pad. A data read returns its synchronised pad value when its input-enable bit (offset 0x18) is 1, and returns 0 when that bit is 0. A line with input enable 0 produces no events.
- R8: For a line whose direction bit is 1, a data read (offset 0x08) returns the value last written to its data bit, whatever the pad level.
- R9: An output line with open-drain bit (offset 0x04) 0 drives `pad_oe`=1 and `pad_out` equal to its data bit. With open-drain bit 1, the line drives low (`pad_oe`=1, `pad_out`=0) when its data bit is 0. It releases the pad (`pad_oe`=0, `pad_out`=0) when its data bit is 1.
- R10: A pad change applied before rising edge k sets the event bit, and therefore `irq_out` if the line is unmasked, right after rising edge k+2 and not earlier.
- R11: Read data appears on `bus_rdata` one clock after a cycle with `bus_rd` high. Offsets other than the seven listed above read as 0, and writes to them change nothing. This includes misaligned offsets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | 32 | Pad levels, index = line number |
| pad_out | output | 32 | Pad drive values, index = line number |
| pad_oe | output | 32 | Pad output enables, index = line number |
| irq_out | output | 1 | Combined interrupt |

## Verification
The following properties are checked on every cycle:
- Event bits are sticky except under an explicit clear.
- A clear always takes effect unless an edge lands in the same cycle, and in that case the edge wins.
- A fully masked event set never raises the interrupt.
- Input lines are never driven.
- An open-drain line never drives high.
- Reset leaves the pads released and the interrupt low.

Only the bench scenarios can show the following:
- The reversed bit order.
- The difference between falling-only and both-edge detection.
- The effect of the input buffer enable.
- That reads of output lines return the written value instead of the pad.
- The exact three-edge latency from a pad change to the interrupt.

// File: rtl/pinbank_pkg.sv
// Shared offsets, register selector type and address decoder for the I/O bank.
package pinbank_pkg;

    localparam logic [7:0] OFS_DIR   = 8'h00;
    localparam logic [7:0] OFS_DRAIN = 8'h04;
    localparam logic [7:0] OFS_DATA  = 8'h08;
    localparam logic [7:0] OFS_EVENT = 8'h0C;
    localparam logic [7:0] OFS_MASK  = 8'h10;
    localparam logic [7:0] OFS_EDGE  = 8'h14;
    localparam logic [7:0] OFS_INEN  = 8'h18;

    typedef enum logic [2:0] {
        SEL_DIR,
        SEL_DRAIN,
        SEL_DATA,
        SEL_EVENT,
        SEL_MASK,
        SEL_EDGE,
        SEL_INEN,
        SEL_NONE
    } reg_sel_e;

    // Map a byte offset onto a register; anything unlisted selects nothing.
    function automatic reg_sel_e decode_offset(input logic [7:0] ofs);
        case (ofs)
            OFS_DIR:   return SEL_DIR;
            OFS_DRAIN: return SEL_DRAIN;
            OFS_DATA:  return SEL_DATA;
            OFS_EVENT: return SEL_EVENT;
            OFS_MASK:  return SEL_MASK;
            OFS_EDGE:  return SEL_EDGE;
            OFS_INEN:  return SEL_INEN;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
// Two-flop synchroniser, one chain per pad line.
// Assumes pad inputs are asynchronous to clk and that a two-cycle latency is acceptable.
module pinbank_sync #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pad_i,
    output logic [LINES-1:0] sync_o
);

    for (genvar n = 0; n < LINES; n++) begin : g_chain
        logic meta_q;
        logic stable_q;

        // Purpose: move one pad level through two flops into the clk domain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q   <= 1'b0;
                stable_q <= 1'b0;
            end else begin
                meta_q   <= pad_i[n];
                stable_q <= meta_q;
            end
        end

        assign sync_o[n] = stable_q;
    end

endmodule

// File: rtl/pinbank_edge.sv
// Per-line edge detector and sticky event latch with write-1-to-clear.
// Assumes level_i is already synchronised and gated; a new edge outranks a clear.
module pinbank_edge #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] level_i,
    input  logic [LINES-1:0] falling_only_i,
    input  logic [LINES-1:0] clear_i,
    output logic [LINES-1:0] hit_o,
    output logic [LINES-1:0] event_o
);

    for (genvar b = 0; b < LINES; b++) begin : g_bit
        logic prev_q;
        logic evt_q;

        // Purpose: remember the level seen in the previous cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= level_i[b];
        end

        assign hit_o[b] = falling_only_i[b] ? (prev_q & ~level_i[b])
                                            : (prev_q ^ level_i[b]);

        // Purpose: hold an event until cleared, letting a new edge win over a clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          evt_q <= 1'b0;
            else if (hit_o[b])   evt_q <= 1'b1;
            else if (clear_i[b]) evt_q <= 1'b0;
        end

        assign event_o[b] = evt_q;
    end

endmodule

// File: rtl/pinbank_regs.sv
// Register file and registered read path for the I/O bank.
// Assumes one-cycle strobes; all vectors here are in register bit order (line n at bit LINES-1-n).
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [LINES-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [LINES-1:0]  bus_rdata,
    input  logic [LINES-1:0]  level_i,
    input  logic [LINES-1:0]  event_i,
    output logic [LINES-1:0]  dir_o,
    output logic [LINES-1:0]  drain_o,
    output logic [LINES-1:0]  data_o,
    output logic [LINES-1:0]  mask_o,
    output logic [LINES-1:0]  falling_o,
    output logic [LINES-1:0]  inen_o,
    output logic [LINES-1:0]  clear_o
);

    reg_sel_e         sel;
    logic [LINES-1:0] rd_val;
    logic [LINES-1:0] rdata_q;

    assign sel = decode_offset(8'(bus_addr));

    // Purpose: update the configuration and data registers on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_o     <= '0;
            drain_o   <= '0;
            data_o    <= '0;
            mask_o    <= '0;
            falling_o <= '0;
            inen_o    <= '0;
        end else if (bus_wr) begin
            case (sel)
                SEL_DIR:   dir_o     <= bus_wdata;
                SEL_DRAIN: drain_o   <= bus_wdata;
                SEL_DATA:  data_o    <= bus_wdata;
                SEL_MASK:  mask_o    <= bus_wdata;
                SEL_EDGE:  falling_o <= bus_wdata;
                SEL_INEN:  inen_o    <= bus_wdata;
                default:   ;
            endcase
        end
    end

    // Purpose: turn a write to the event register into a one-cycle clear mask.
    assign clear_o = (bus_wr && sel == SEL_EVENT) ? bus_wdata : '0;

    // Purpose: select read data; outputs show the written value, inputs the gated pad.
    always_comb begin
        case (sel)
            SEL_DIR:   rd_val = dir_o;
            SEL_DRAIN: rd_val = drain_o;
            SEL_DATA:  rd_val = (dir_o & data_o) | (~dir_o & level_i);
            SEL_EVENT: rd_val = event_i;
            SEL_MASK:  rd_val = mask_o;
            SEL_EDGE:  rd_val = falling_o;
            SEL_INEN:  rd_val = inen_o;
            default:   rd_val = '0;
        endcase
    end

    // Purpose: register read data one cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_val;
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/pinbank_ctrl.sv
// Top of the I/O bank: synchroniser, register file, edge/event logic, pad drive and interrupt.
// Assumes pads are indexed by line while registers hold line n at bit LINES-1-n.
module pinbank_ctrl #(
    parameter int LINES  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [LINES-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [LINES-1:0]  bus_rdata,
    input  logic [LINES-1:0]  pad_in,
    output logic [LINES-1:0]  pad_out,
    output logic [LINES-1:0]  pad_oe,
    output logic              irq_out
);

    logic [LINES-1:0] sync_line;
    logic [LINES-1:0] sync_bits;
    logic [LINES-1:0] level_bits;
    logic [LINES-1:0] dir_w;
    logic [LINES-1:0] drain_w;
    logic [LINES-1:0] data_w;
    logic [LINES-1:0] mask_w;
    logic [LINES-1:0] fall_w;
    logic [LINES-1:0] inen_w;
    logic [LINES-1:0] clr_w;
    logic [LINES-1:0] hit_w;
    logic [LINES-1:0] evt_w;
    logic [LINES-1:0] oe_bits;
    logic [LINES-1:0] out_bits;

    pinbank_sync #(.LINES(LINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_i  (pad_in),
        .sync_o (sync_line)
    );

    // Purpose: convert between pad (line) order and register (reversed) order.
    for (genvar n = 0; n < LINES; n++) begin : g_order
        assign sync_bits[LINES-1-n] = sync_line[n];
        assign pad_oe[n]            = oe_bits[LINES-1-n];
        assign pad_out[n]           = out_bits[LINES-1-n];
    end

    // Purpose: only enabled input buffers pass the pad level onward.
    assign level_bits = sync_bits & inen_w;

    pinbank_regs #(.LINES(LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .level_i   (level_bits),
        .event_i   (evt_w),
        .dir_o     (dir_w),
        .drain_o   (drain_w),
        .data_o    (data_w),
        .mask_o    (mask_w),
        .falling_o (fall_w),
        .inen_o    (inen_w),
        .clear_o   (clr_w)
    );

    pinbank_edge #(.LINES(LINES)) u_edge (
        .clk            (clk),
        .rst_n          (rst_n),
        .level_i        (level_bits),
        .falling_only_i (fall_w),
        .clear_i        (clr_w),
        .hit_o          (hit_w),
        .event_o        (evt_w)
    );

    // Purpose: push-pull drives the data bit; open-drain only ever pulls low.
    assign oe_bits  = dir_w & (~drain_w | ~data_w);
    assign out_bits = dir_w & ~drain_w & data_w;

    // Purpose: combine unmasked events into one interrupt.
    assign irq_out = |(evt_w & mask_w);

endmodule

// File: rtl/pinbank_ctrl_chk.sv
// Cycle-by-cycle property checker for pinbank_ctrl, attached with bind.
// Assumes default parameters of the bound top.
module pinbank_ctrl_chk
    import pinbank_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [LINES-1:0]  bus_wdata,
    input logic              irq_out,
    input logic [LINES-1:0]  evt_w,
    input logic [LINES-1:0]  hit_w,
    input logic [LINES-1:0]  mask_w,
    input logic [LINES-1:0]  dir_w,
    input logic [LINES-1:0]  drain_w,
    input logic [LINES-1:0]  oe_bits,
    input logic [LINES-1:0]  out_bits
);

    logic evt_write;
    assign evt_write = bus_wr && (bus_addr == ADDR_W'(OFS_EVENT));

    // R1: reset leaves pads released and the interrupt low.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (oe_bits == '0 && !irq_out));

    // R3: a cleared bit is gone next cycle unless an edge hit it.
    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_write |=> ((evt_w & $past(bus_wdata) & ~$past(hit_w)) == '0));

    // R3: without a clear, no event bit falls.
    assert_evt_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_write |=> (($past(evt_w) & ~evt_w) == '0));

    // R4: every detected edge is latched, clear or not.
    assert_edge_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_w != '0) |=> (($past(hit_w) & ~evt_w) == '0));

    // R5: nothing unmasked means no interrupt.
    assert_mask_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_w & mask_w) == '0) |-> !irq_out);

    // R7: an input line never enables its driver.
    assert_input_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_bits & ~dir_w) == '0);

    // R9: an open-drain line never drives high.
    assert_drain_no_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_bits & drain_w) == '0);

endmodule

bind pinbank_ctrl pinbank_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .irq_out   (irq_out),
    .evt_w     (evt_w),
    .hit_w     (hit_w),
    .mask_w    (mask_w),
    .dir_w     (dir_w),
    .drain_w   (drain_w),
    .oe_bits   (oe_bits),
    .out_bits  (out_bits)
);

// File: tb/pinbank_ctrl_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected words, a monitor compares bus_rdata.
module pinbank_ctrl_tb_top;
    import pinbank_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #2 clk = ~clk;

    pinbank_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
    );

    // Register bit of line n (reversed order).
    function automatic logic [31:0] lb(input int n);
        return 32'h1 << (31 - n);
    endfunction

    always @(posedge clk) rd_seen <= bus_rd;

    // Monitor: pop and compare one expected word per completed read.
    always @(negedge clk) begin
        logic [31:0] e;
        string t;
        if (rd_seen) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: read with empty queue, got %h expected nothing", bus_rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: rdata %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: got %h expected %h", t, act, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        chk(pad_oe, 32'h0, "R1 pad_oe after reset");
        chk({31'h0, irq_out}, 32'h0, "R1 irq after reset");
        rd(OFS_DIR, 0, "R1 dir"); rd(OFS_DRAIN, 0, "R1 drain");
        rd(OFS_DATA, 0, "R1 data"); rd(OFS_EVENT, 0, "R1 event");
        rd(OFS_MASK, 0, "R1 mask"); rd(OFS_EDGE, 0, "R1 edge");
        rd(OFS_INEN, 0, "R1 inen");
        // R11 unmapped and misaligned offsets
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h1C, 0, "R11 unmapped reads zero");
        wr(8'h02, 32'hFFFF_FFFF);
        rd(OFS_DIR, 0, "R11 misaligned write ignored");
        // R2 / R7 / R6 both-edge rising on lines 0 and 3
        wr(OFS_INEN, 32'hFFFF_FFFF);
        pad_in = 32'h0000_0009;
        idle(4);
        rd(OFS_DATA, lb(0) | lb(3), "R2 R7 input lines read reversed");
        rd(OFS_EVENT, lb(0) | lb(3), "R2 R6 both-edge rising sets events");
        // R5 mask, R3 single-bit clear
        chk({31'h0, irq_out}, 32'h0, "R5 irq low with mask zero");
        wr(OFS_MASK, lb(3));
        chk({31'h0, irq_out}, 32'h1, "R5 irq high with unmasked event");
        wr(OFS_EVENT, lb(3));
        chk({31'h0, irq_out}, 32'h0, "R3 R5 irq drops after clear");
        rd(OFS_EVENT, lb(0), "R3 other event untouched");
        wr(OFS_EVENT, 32'hFFFF_FFFF);
        rd(OFS_EVENT, 0, "R3 clear all");
        // R6 falling-only on line 5, both-edge on line 6
        wr(OFS_EDGE, lb(5));
        pad_in[5] = 1'b1; pad_in[6] = 1'b1;
        idle(4);
        rd(OFS_EVENT, lb(6), "R6 rising ignored in falling-only mode");
        wr(OFS_EVENT, 32'hFFFF_FFFF);
        pad_in[5] = 1'b0; pad_in[6] = 1'b0;
        idle(4);
        rd(OFS_EVENT, lb(5) | lb(6), "R6 falling seen in both modes");
        wr(OFS_EVENT, 32'hFFFF_FFFF);
        // R7 input buffer disabled on line 7
        wr(OFS_INEN, ~lb(7));
        pad_in[7] = 1'b1;
        idle(4);
        rd(OFS_DATA, lb(0) | lb(3), "R7 disabled buffer reads zero");
        rd(OFS_EVENT, 0, "R7 disabled buffer makes no event");
        chk(pad_oe, 32'h0, "R7 input lines not driven");
        // R8 / R9 outputs: line 8 push-pull, line 9 open-drain
        wr(OFS_DIR, lb(8) | lb(9));
        wr(OFS_DRAIN, lb(9));
        wr(OFS_DATA, lb(8) | lb(1));
        chk(pad_oe, 32'h0000_0300, "R9 push-pull and drain-low enables");
        chk(pad_out, 32'h0000_0100, "R9 push-pull high, drain low");
        rd(OFS_DATA, lb(0) | lb(3) | lb(8), "R8 outputs read written, inputs read pad");
        pad_in[9] = 1'b1;
        idle(4);
        rd(OFS_DATA, lb(0) | lb(3) | lb(8), "R8 output line ignores pad");
        wr(OFS_DATA, lb(8) | lb(9));
        chk(pad_oe, 32'h0000_0100, "R9 open-drain releases on one");
        chk(pad_out, 32'h0000_0100, "R9 released line drives zero");
        wr(OFS_EVENT, 32'hFFFF_FFFF);
        rd(OFS_EVENT, 0, "R3 clear before timing test");
        // R10 latency on line 11
        wr(OFS_MASK, lb(11));
        pad_in[11] = 1'b1;
        idle(1);
        chk({31'h0, irq_out}, 32'h0, "R10 no irq after edge k");
        idle(1);
        chk({31'h0, irq_out}, 32'h0, "R10 no irq after edge k+1");
        idle(1);
        chk({31'h0, irq_out}, 32'h1, "R10 irq after edge k+2");
        // R4 edge and clear in the same cycle on line 10
        wr(OFS_MASK, 32'h0);
        wr(OFS_EVENT, 32'hFFFF_FFFF);
        pad_in[10] = 1'b1;
        idle(2);
        wr(OFS_EVENT, lb(10));
        rd(OFS_EVENT, lb(10), "R4 edge wins over same-cycle clear");
        wr(OFS_EVENT, lb(10));
        rd(OFS_EVENT, 0, "R3 later clear succeeds");
        idle(3);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule